// File: doc/BRIEF.md
# Conditional Near Branch Resolver

This block settles the outcome of a relative near branch in a 32-bit pipeline. Each request gives the address of the next instruction, a signed 32-bit displacement, a 4-bit condition code and the five arithmetic flags (overflow, carry, zero, sign, parity). A separate strobe marks an unconditional jump. The block decides whether the branch is taken and forms the target by adding the displacement to the next-instruction address. A taken target is then compared with the code segment limit. If it is within the limit, the block writes the instruction pointer. If it is past the limit, the block raises a general-protection fault with a zero error code and leaves the pointer alone. The limit check is made the same way in every operating mode.

Requests arrive as single-cycle `req_valid` pulses. The block has no ready signal and never applies back-pressure, so a request may be presented on every cycle, back to back. Every result appears on the registered outputs exactly one cycle after its request and is marked by `res_valid`. The consumer must take the result in that cycle, because the block keeps no queue. The result strobes (`taken`, `fault`, `ip_we`) are low in every cycle that has no result.

Top module: `nbr_resolver`

## Requirements
- R1: The target equals `next_ip + disp`, taken modulo 2^32, so a sum past 0xFFFFFFFF wraps around to a low address.
- R2: `cond_sel` codes 0/1 test OF set/clear, 2/3 test CF set/clear, 4/5 test ZF set/clear, 8/9 test SF set/clear and 10/11 test PF set/clear. Bit 0 of the code inverts the predicate named by bits 3:1.
- R3: Code 6 is taken when CF or ZF is set. Code 7 is taken when both CF and ZF are clear.
- R4: Code 12 is taken when SF differs from OF. Code 13 is taken when SF equals OF.
- R5: Code 14 is taken when ZF is set or SF differs from OF. Code 15 is taken when ZF is clear and SF equals OF.
- R6: When `uncond` is high, the branch is taken whatever the condition code and flags are.
- R7: When a taken target is strictly greater than `cs_limit`, the block raises `fault` with `err_code` = 0, keeps `ip_we` low and returns `new_ip` equal to `next_ip`. A target exactly equal to `cs_limit` does not fault.
- R8: When a taken target is within the limit, the block raises `ip_we`, returns `new_ip` equal to the target and keeps `fault` low.
- R9: A branch that is not taken raises neither `fault` nor `ip_we`, and returns `new_ip` equal to `next_ip`, even when its target lies past the limit.
- R10: Every output is registered. `res_valid` rises exactly one cycle after `req_valid`. All strobes and `new_ip` are zero after reset, and the strobes are low in any cycle that has no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per branch |
| next_ip | input | 32 | Address of the instruction after the branch |
| disp | input | 32 | Signed displacement |
| cond_sel | input | 4 | Condition code |
| flag_of | input | 1 | Overflow flag |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_pf | input | 1 | Parity flag |
| uncond | input | 1 | Forces the branch to be taken |
| cs_limit | input | 32 | Highest legal code offset |
| res_valid | output | 1 | A result is present |
| taken | output | 1 | The branch decision |
| new_ip | output | 32 | The resulting instruction pointer |
| fault | output | 1 | General-protection fault strobe |
| err_code | output | 16 | Fault error code, always zero |
| ip_we | output | 1 | Instruction-pointer write enable |

## Verification
Both the branch decision and the limit check act on every request. The interesting cases are the ones where their outcomes conflict. To test this, the bench gives a target one past the limit to two requests. For the first, the condition holds, and the bench expects a fault with no pointer write. For the second, the condition fails, and the bench expects no strobe at all. The unconditional strobe is also combined with a condition code whose predicate is false, and a taken target is placed exactly on the limit. In each case the bench compares the strobes and `new_ip` with values it derives from the requirement rules.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  // Condition codes; bit 0 inverts the predicate chosen by bits 3:1
  typedef enum logic [3:0] {
    CC_OVF   = 4'd0,  CC_NOVF  = 4'd1,
    CC_CARRY = 4'd2,  CC_NCARRY = 4'd3,
    CC_ZERO  = 4'd4,  CC_NZERO = 4'd5,
    CC_ULE   = 4'd6,  CC_UGT   = 4'd7,
    CC_NEG   = 4'd8,  CC_NNEG  = 4'd9,
    CC_PAR   = 4'd10, CC_NPAR  = 4'd11,
    CC_SLT   = 4'd12, CC_SGE   = 4'd13,
    CC_SLE   = 4'd14, CC_SGT   = 4'd15
  } cc_e;

  typedef struct packed {
    logic ovf;
    logic carry;
    logic zero;
    logic neg;
    logic par;
  } flags_t;

  localparam int unsigned ERR_W = 16;

endpackage

// File: rtl/nbr_cond_eval.sv
module nbr_cond_eval
  import nbr_pkg::*;
(
  input  logic [3:0] sel,
  input  flags_t     fl,
  output logic       pass
);

  logic base;
  logic lt;

  assign lt = fl.neg ^ fl.ovf;

  // Bits 3:1 pick the base predicate (R2..R5)
  always_comb begin
    unique case (sel[3:1])
      3'd0: base = fl.ovf;
      3'd1: base = fl.carry;
      3'd2: base = fl.zero;
      3'd3: base = fl.carry | fl.zero;
      3'd4: base = fl.neg;
      3'd5: base = fl.par;
      3'd6: base = lt;
      default: base = fl.zero | lt;
    endcase
  end

  assign pass = base ^ sel[0];

endmodule

// File: rtl/nbr_target_calc.sv
module nbr_target_calc #(
  parameter int unsigned IPW = 32
) (
  input  logic [IPW-1:0] base_ip,
  input  logic [IPW-1:0] offset,
  input  logic [IPW-1:0] limit,
  output logic [IPW-1:0] target,
  output logic           beyond
);

  // Modular add: carry out is discarded (R1)
  assign target = base_ip + offset;
  assign beyond = target > limit;

endmodule

// File: rtl/nbr_resolver.sv
module nbr_resolver
  import nbr_pkg::*;
#(
  parameter int unsigned IPW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IPW-1:0]   next_ip,
  input  logic [IPW-1:0]   disp,
  input  logic [3:0]       cond_sel,
  input  logic             flag_of,
  input  logic             flag_cf,
  input  logic             flag_zf,
  input  logic             flag_sf,
  input  logic             flag_pf,
  input  logic             uncond,
  input  logic [IPW-1:0]   cs_limit,
  output logic             res_valid,
  output logic             taken,
  output logic [IPW-1:0]   new_ip,
  output logic             fault,
  output logic [ERR_W-1:0] err_code,
  output logic             ip_we
);

  flags_t         fl;
  logic           cond_ok;
  logic           go;
  logic [IPW-1:0] tgt;
  logic           over;

  assign fl = '{ovf: flag_of, carry: flag_cf, zero: flag_zf,
                neg: flag_sf, par: flag_pf};

  nbr_cond_eval u_cond (
    .sel  (cond_sel),
    .fl   (fl),
    .pass (cond_ok)
  );

  nbr_target_calc #(.IPW(IPW)) u_tgt (
    .base_ip (next_ip),
    .offset  (disp),
    .limit   (cs_limit),
    .target  (tgt),
    .beyond  (over)
  );

  assign go = uncond | cond_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      taken     <= 1'b0;
      fault     <= 1'b0;
      ip_we     <= 1'b0;
      new_ip    <= '0;
    end else begin
      res_valid <= req_valid;
      taken     <= req_valid & go;
      fault     <= req_valid & go & over;
      ip_we     <= req_valid & go & ~over;
      if (req_valid)
        new_ip <= (go && !over) ? tgt : next_ip;
    end
  end

  // The only fault raised here is general protection, code zero (R7)
  assign err_code = '0;

endmodule

// File: rtl/nbr_resolver_chk.sv
module nbr_resolver_chk #(
  parameter int unsigned IPW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           uncond,
  input logic [IPW-1:0] next_ip,
  input logic [IPW-1:0] disp,
  input logic [IPW-1:0] cs_limit,
  input logic           res_valid,
  input logic           taken,
  input logic           fault,
  input logic           ip_we,
  input logic [IPW-1:0] new_ip
);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || ip_we || taken) |-> res_valid);

  assert_fault_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !ip_we && taken);

  assert_fault_past_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid ##1 fault |-> (($past(next_ip) + $past(disp)) > $past(cs_limit)));

  assert_write_in_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid ##1 ip_we |-> new_ip <= $past(cs_limit));

  assert_target_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid ##1 ip_we |-> new_ip == $past(next_ip) + $past(disp));

  assert_untaken_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !taken) |-> !fault && !ip_we);

  assert_uncond_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && uncond) |=> taken);

endmodule

bind nbr_resolver nbr_resolver_chk #(.IPW(IPW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .uncond    (uncond),
  .next_ip   (next_ip),
  .disp      (disp),
  .cs_limit  (cs_limit),
  .res_valid (res_valid),
  .taken     (taken),
  .fault     (fault),
  .ip_we     (ip_we),
  .new_ip    (new_ip)
);

// File: tb/nbr_resolver_tb.sv
module nbr_resolver_tb_top;

  typedef struct packed {
    logic [31:0] ip;
    logic [31:0] dsp;
    logic [3:0]  cc;
    logic [4:0]  fl;   // {OF, CF, ZF, SF, PF}
    logic        unc;
    logic [31:0] lim;
    logic        t;
    logic        f;
  } vec_t;

  localparam int NV = 23;
  localparam logic [31:0] FULL = 32'hFFFF_FFFF;

  localparam vec_t VEC [NV] = '{
    '{32'h1000, 32'h10, 4'd0, 5'b10000, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h1000, 32'h10, 4'd1, 5'b10000, 1'b0, FULL, 1'b0, 1'b0},
    '{32'h2000, 32'h40, 4'd2, 5'b01000, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h1000, 32'hFFFF_FFF0, 4'd3, 5'b00000, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h1000, 32'h10, 4'd4, 5'b00000, 1'b0, FULL, 1'b0, 1'b0},
    '{32'h3000, 32'h8, 4'd5, 5'b00000, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h3000, 32'h8, 4'd6, 5'b00100, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h3000, 32'h8, 4'd7, 5'b00000, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h3000, 32'h8, 4'd7, 5'b01000, 1'b0, FULL, 1'b0, 1'b0},
    '{32'h4000, 32'h100, 4'd8, 5'b00010, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h4000, 32'h100, 4'd9, 5'b00010, 1'b0, FULL, 1'b0, 1'b0},
    '{32'h4000, 32'h100, 4'd10, 5'b00001, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h4000, 32'h100, 4'd11, 5'b00001, 1'b0, FULL, 1'b0, 1'b0},
    '{32'h5000, 32'h20, 4'd12, 5'b00010, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h5000, 32'h20, 4'd13, 5'b10010, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h5000, 32'h20, 4'd14, 5'b00000, 1'b0, FULL, 1'b0, 1'b0},
    '{32'h5000, 32'h20, 4'd15, 5'b10010, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h5000, 32'h20, 4'd14, 5'b00100, 1'b0, FULL, 1'b1, 1'b0},
    '{32'h6000, 32'h4, 4'd1, 5'b10000, 1'b1, FULL, 1'b1, 1'b0},
    '{32'hFFFF_FFF0, 32'h20, 4'd0, 5'b00000, 1'b1, 32'hFFFF, 1'b1, 1'b0},
    '{32'h100, 32'hF00, 4'd5, 5'b00000, 1'b0, 32'h1000, 1'b1, 1'b0},
    '{32'h100, 32'hF00, 4'd5, 5'b00000, 1'b0, 32'h0FFF, 1'b1, 1'b1},
    '{32'h100, 32'hF00, 4'd1, 5'b10000, 1'b0, 32'h0FFF, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] next_ip = '0;
  logic [31:0] disp = '0;
  logic [3:0]  cond_sel = '0;
  logic        flag_of = 1'b0, flag_cf = 1'b0, flag_zf = 1'b0;
  logic        flag_sf = 1'b0, flag_pf = 1'b0;
  logic        uncond = 1'b0;
  logic [31:0] cs_limit = '1;
  logic        res_valid, taken, fault, ip_we;
  logic [31:0] new_ip;
  logic [15:0] err_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nbr_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .next_ip(next_ip),
    .disp(disp), .cond_sel(cond_sel), .flag_of(flag_of), .flag_cf(flag_cf),
    .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_pf(flag_pf), .uncond(uncond),
    .cs_limit(cs_limit), .res_valid(res_valid), .taken(taken), .new_ip(new_ip),
    .fault(fault), .err_code(err_code), .ip_we(ip_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.unc) return "R6";
    if (v.lim != FULL) return v.t ? "R7" : "R9";
    case (v.cc)
      4'd6, 4'd7:   return "R3";
      4'd12, 4'd13: return "R4";
      4'd14, 4'd15: return "R5";
      default:      return "R2";
    endcase
  endfunction

  task automatic drive(input vec_t v);
    req_valid = 1'b1;
    next_ip   = v.ip;
    disp      = v.dsp;
    cond_sel  = v.cc;
    {flag_of, flag_cf, flag_zf, flag_sf, flag_pf} = v.fl;
    uncond    = v.unc;
    cs_limit  = v.lim;
  endtask

  // Called one negedge after the request edge
  task automatic judge(input vec_t v);
    logic        we_e;
    logic [31:0] ip_e;
    we_e = v.t & ~v.f;
    ip_e = we_e ? v.ip + v.dsp : v.ip;
    check("R10 res_valid", {31'd0, res_valid}, 32'd1);
    check(tag_of(v), {31'd0, taken}, {31'd0, v.t});
    check("R7 fault", {31'd0, fault}, {31'd0, v.f});
    check("R8 ip_we", {31'd0, ip_we}, {31'd0, we_e});
    check("R1 new_ip", new_ip, ip_e);
    if (v.f) check("R7 err_code", {16'd0, err_code}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset res_valid", {31'd0, res_valid}, 32'd0);
    check("R10 reset strobes", {29'd0, taken, fault, ip_we}, 32'd0);
    check("R10 reset new_ip", new_ip, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk, back to back: check previous result while driving next
    drive(VEC[0]);
    for (int i = 1; i <= NV; i++) begin
      @(negedge clk);
      if (i < NV) begin
        judge(VEC[i-1]);
        drive(VEC[i]);
      end else begin
        req_valid = 1'b0;
        judge(VEC[i-1]);
      end
    end

    // R10: idle cycle leaves strobes low
    @(negedge clk);
    check("R10 idle res_valid", {31'd0, res_valid}, 32'd0);
    check("R10 idle strobes", {29'd0, taken, fault, ip_we}, 32'd0);

    // R6 with a fault: unconditional jump beyond limit (R7)
    drive('{32'h8000, 32'h10, 4'd0, 5'b00000, 1'b1, 32'h800F, 1'b1, 1'b1});
    @(negedge clk);
    req_valid = 1'b0;
    judge('{32'h8000, 32'h10, 4'd0, 5'b00000, 1'b1, 32'h800F, 1'b1, 1'b1});

    // R1: negative displacement wrapping below zero
    drive('{32'h8, 32'hFFFF_FFF0, 4'd0, 5'b00000, 1'b1, FULL, 1'b1, 1'b0});
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 wrap below zero", new_ip, 32'hFFFF_FFF8);

    // R10: reset clears a pending result
    drive(VEC[0]);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears result", {29'd0, res_valid, taken, ip_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule